// File: doc/BRIEF.md
# Memory-Mapped Register File Decoder

This block holds the general registers of a small 8-bit processor: 32 registers of 8 bits, read through two combinational operand ports and written through one instruction write port. The same registers also sit at the bottom of the data address space. A data-memory port takes a 16-bit data address and decides where it goes. The lowest 32 addresses reach the registers directly. The next 64 addresses go to peripheral I/O registers. Everything from 0x60 upward goes to SRAM.

The I/O registers and the SRAM are outside the block. For those regions the block only produces a select strobe and a region-relative address, and it returns the read data that the outside supplies. The six highest registers are also presented as three 16-bit pointers. Each of the three operand index inputs has a short mode for immediate-style instructions. In that mode only the low four bits of the index field count, and they address the upper half of the file.

Top module: `regmap_file`

## Requirements
- R1: A synchronous reset, active low, clears every register to 0x00. After reset, both read ports and all three pointers read zero.
- R2: Read ports are combinational. An instruction write (`wr_en`) updates the addressed register at the clock edge. The new value appears on the read ports from the following cycle, not in the cycle of the write.
- R3: When a port's short-mode input is 1, its register index is 16 plus the low four bits of its index field, so it reaches r16 to r31. Bit 4 of the field is ignored. This applies to both read ports and to the write port.
- R4: A data access with address 0x0000 to 0x001F reaches register r[address]. A write (`mem_wr`) updates that register. A read (`mem_rd`) returns its value on `mem_rdata`.
- R5: An access with address 0x0020 to 0x005F raises `io_sel` and drives `io_addr` = address − 0x20 (6 bits). It leaves every register unchanged.
- R6: An access with address 0x0060 or above raises `sram_sel` and drives `sram_addr` = address − 0x60. It leaves every register unchanged.
- R7: `ptr_x` = {r27, r26}, `ptr_y` = {r29, r28` and `ptr_z` = {r31, r30}. In each pointer the lower-numbered register is the low byte.
- R8: If an instruction write and a data-port write target the same register in one cycle, the instruction value is stored. If they target different registers, both are stored.
- R9: `mem_rdata` returns the addressed register for the register region, `io_rdata` for the I/O region and `sram_rdata` for the SRAM region.
- R10: `io_sel` and `sram_sel` are 0 when neither `mem_rd` nor `mem_wr` is set. An access in the register region raises neither of them. At most one of them is 1 at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ra_idx | input | 5 | Read port A register field |
| ra_short | input | 1 | Read port A short (upper-half) mode |
| ra_data | output | 8 | Read port A data |
| rb_idx | input | 5 | Read port B register field |
| rb_short | input | 1 | Read port B short (upper-half) mode |
| rb_data | output | 8 | Read port B data |
| wr_en | input | 1 | Instruction write enable |
| wr_idx | input | 5 | Instruction write register field |
| wr_short | input | 1 | Write port short (upper-half) mode |
| wr_data | input | 8 | Instruction write data |
| mem_addr | input | 16 | Data address |
| mem_rd | input | 1 | Data read request |
| mem_wr | input | 1 | Data write request |
| mem_wdata | input | 8 | Data write value |
| mem_rdata | output | 8 | Data read value |
| io_rdata | input | 8 | Read data returned by the I/O registers |
| sram_rdata | input | 8 | Read data returned by the SRAM |
| io_sel | output | 1 | I/O region select |
| io_addr | output | 6 | I/O register offset |
| sram_sel | output | 1 | SRAM region select |
| sram_addr | output | 16 | SRAM offset |
| ptr_x | output | 16 | Pointer from r27:r26 |
| ptr_y | output | 16 | Pointer from r29:r28 |
| ptr_z | output | 16 | Pointer from r31:r30 |

## Verification
The assertions take for granted that `mem_rd` and `mem_wr` are not both set in one cycle. They also take for granted that every input is held stable for a whole clock period, so the value sampled at an edge is the value the address decode used. The bench changes inputs only on falling edges, never raises both data-port requests together, and returns every enable to zero once its cycle has been used. The collision case is driven on purpose, with both write sources pointing at one register in the same cycle.

// File: rtl/regmap_pkg.sv
// Shared definitions for the memory-mapped register file.
// Assumes: nothing beyond IEEE 1800-2017.
package regmap_pkg;
    // Which part of the data address space an access falls into.
    typedef enum logic [1:0] {
        RGN_REG  = 2'd0,
        RGN_IO   = 2'd1,
        RGN_SRAM = 2'd2
    } region_e;
endpackage

// File: rtl/regmap_operand_map.sv
// Maps an instruction register field to a file index.
// In short mode only the low IDX_W-1 bits are used, and the result
// points into the upper half of the file.
// Assumes: IDX_W >= 2.
module regmap_operand_map #(
    parameter int IDX_W = 5
) (
    input  logic [IDX_W-1:0] field,
    input  logic             short_mode,
    output logic [IDX_W-1:0] idx
);
    // Select between the full field and the upper-half form.
    always_comb begin
        if (short_mode) idx = {1'b1, field[IDX_W-2:0]};
        else            idx = field;
    end
endmodule

// File: rtl/regmap_addr_decode.sv
// Splits a data address into the register, I/O and SRAM regions.
// Produces the region-relative offsets and the select strobes.
// Assumes: rd and wr are never both high.
module regmap_addr_decode
    import regmap_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int NUM_REGS = 32,
    parameter int IO_COUNT = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    output region_e           region,
    output logic              reg_we,
    output logic              io_sel,
    output logic [$clog2(IO_COUNT)-1:0] io_addr,
    output logic              sram_sel,
    output logic [ADDR_W-1:0] sram_addr
);
    localparam int IO_AW = $clog2(IO_COUNT);
    localparam logic [ADDR_W-1:0] IO_BASE   = ADDR_W'(NUM_REGS);
    localparam logic [ADDR_W-1:0] SRAM_BASE = ADDR_W'(NUM_REGS + IO_COUNT);

    logic access;

    // Classify the address by comparing it against the region bases.
    always_comb begin
        if (addr < IO_BASE)        region = RGN_REG;
        else if (addr < SRAM_BASE) region = RGN_IO;
        else                       region = RGN_SRAM;
    end

    // Build the strobes and the offsets inside each region.
    always_comb begin
        access    = rd | wr;
        reg_we    = wr && (region == RGN_REG);
        io_sel    = access && (region == RGN_IO);
        sram_sel  = access && (region == RGN_SRAM);
        io_addr   = IO_AW'(addr - IO_BASE);
        sram_addr = addr - SRAM_BASE;
    end

    // R10: at most one target is driven in any cycle.
    a_r10_one_target: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({reg_we, io_sel, sram_sel}));
    // R5: the I/O strobe is only raised inside the I/O window.
    a_r5_io_window: assert property (@(posedge clk) disable iff (!rst_n)
        io_sel |-> (addr >= IO_BASE && addr < SRAM_BASE));
    // R6: the SRAM strobe is only raised at or above the SRAM base.
    a_r6_sram_window: assert property (@(posedge clk) disable iff (!rst_n)
        sram_sel |-> (addr >= SRAM_BASE));
endmodule

// File: rtl/regmap_storage.sv
// Register array with two write sources. Source A (instruction) has
// priority over source B (data port) when both target one entry.
// The whole array is exposed so the parent can build read ports.
// Assumes: synchronous active-low reset clears all entries.
module regmap_storage #(
    parameter int NUM_REGS = 32,
    parameter int DATA_W   = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we_a,
    input  logic [$clog2(NUM_REGS)-1:0] idx_a,
    input  logic [DATA_W-1:0]          d_a,
    input  logic                       we_b,
    input  logic [$clog2(NUM_REGS)-1:0] idx_b,
    input  logic [DATA_W-1:0]          d_b,
    output logic [NUM_REGS-1:0][DATA_W-1:0] q
);
    logic b_blocked;

    // Source B loses when source A writes the same entry.
    always_comb b_blocked = we_a && (idx_a == idx_b);

    // Clear on reset, then apply the enabled writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            if (we_b && !b_blocked) q[idx_b] <= d_b;
            if (we_a)               q[idx_a] <= d_a;
        end
    end

    // R2 / R8: an instruction write is always what the entry holds next.
    a_r8_instr_lands: assert property (@(posedge clk) disable iff (!rst_n)
        we_a |=> (q[$past(idx_a)] == $past(d_a)));
    // R4: an unblocked data-port write lands.
    a_r4_mem_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (we_b && !(we_a && idx_a == idx_b)) |=> (q[$past(idx_b)] == $past(d_b)));
endmodule

// File: rtl/regmap_file.sv
// Top of the memory-mapped register file. It provides two operand
// read ports and one instruction write port, a data-memory port
// decoded into register, I/O and SRAM regions, and three 16-bit
// pointers formed from the six highest registers.
// Assumes: mem_rd and mem_wr are mutually exclusive; NUM_REGS >= 6.
module regmap_file
    import regmap_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int NUM_REGS = 32,
    parameter int ADDR_W   = 16,
    parameter int IO_COUNT = 64
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [$clog2(NUM_REGS)-1:0]  ra_idx,
    input  logic                         ra_short,
    output logic [DATA_W-1:0]            ra_data,
    input  logic [$clog2(NUM_REGS)-1:0]  rb_idx,
    input  logic                         rb_short,
    output logic [DATA_W-1:0]            rb_data,
    input  logic                         wr_en,
    input  logic [$clog2(NUM_REGS)-1:0]  wr_idx,
    input  logic                         wr_short,
    input  logic [DATA_W-1:0]            wr_data,
    input  logic [ADDR_W-1:0]            mem_addr,
    input  logic                         mem_rd,
    input  logic                         mem_wr,
    input  logic [DATA_W-1:0]            mem_wdata,
    output logic [DATA_W-1:0]            mem_rdata,
    input  logic [DATA_W-1:0]            io_rdata,
    input  logic [DATA_W-1:0]            sram_rdata,
    output logic                         io_sel,
    output logic [$clog2(IO_COUNT)-1:0]  io_addr,
    output logic                         sram_sel,
    output logic [ADDR_W-1:0]            sram_addr,
    output logic [2*DATA_W-1:0]          ptr_x,
    output logic [2*DATA_W-1:0]          ptr_y,
    output logic [2*DATA_W-1:0]          ptr_z
);
    localparam int IDX_W   = $clog2(NUM_REGS);
    localparam int NUM_PTR = 3;
    localparam int PTR_LO  = NUM_REGS - 2 * NUM_PTR;

    logic [IDX_W-1:0] ra_map, rb_map, wr_map, mem_idx;
    logic [NUM_REGS-1:0][DATA_W-1:0] regs;
    logic [NUM_PTR-1:0][2*DATA_W-1:0] ptrs;
    region_e region;
    logic    reg_we;

    regmap_operand_map #(.IDX_W(IDX_W)) u_map_a (
        .field(ra_idx), .short_mode(ra_short), .idx(ra_map));
    regmap_operand_map #(.IDX_W(IDX_W)) u_map_b (
        .field(rb_idx), .short_mode(rb_short), .idx(rb_map));
    regmap_operand_map #(.IDX_W(IDX_W)) u_map_w (
        .field(wr_idx), .short_mode(wr_short), .idx(wr_map));

    regmap_addr_decode #(
        .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .IO_COUNT(IO_COUNT)
    ) u_decode (
        .clk(clk), .rst_n(rst_n), .addr(mem_addr), .rd(mem_rd), .wr(mem_wr),
        .region(region), .reg_we(reg_we), .io_sel(io_sel), .io_addr(io_addr),
        .sram_sel(sram_sel), .sram_addr(sram_addr)
    );

    // The register region uses the low address bits as the index.
    always_comb mem_idx = mem_addr[IDX_W-1:0];

    regmap_storage #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .we_a(wr_en), .idx_a(wr_map), .d_a(wr_data),
        .we_b(reg_we), .idx_b(mem_idx), .d_b(mem_wdata),
        .q(regs)
    );

    // Combinational operand reads.
    always_comb begin
        ra_data = regs[ra_map];
        rb_data = regs[rb_map];
    end

    // Return data for the data port, chosen by region.
    always_comb begin
        unique case (region)
            RGN_REG:  mem_rdata = regs[mem_idx];
            RGN_IO:   mem_rdata = io_rdata;
            default:  mem_rdata = sram_rdata;
        endcase
    end

    // Each pointer pairs two adjacent registers, the lower one as the low byte.
    for (genvar p = 0; p < NUM_PTR; p++) begin : g_ptr
        assign ptrs[p] = {regs[PTR_LO + 2*p + 1], regs[PTR_LO + 2*p]};
    end

    // Route the pointer pairs to their named ports.
    always_comb begin
        ptr_x = ptrs[0];
        ptr_y = ptrs[1];
        ptr_z = ptrs[2];
    end

    // R9: register-region reads never return external data when it differs.
    a_r9_reg_read_src: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && !io_sel && !sram_sel) |-> (mem_rdata == regs[mem_idx]));
endmodule

// File: tb/regmap_file_tb.sv
module regmap_file_tb;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [4:0]  ra_idx, rb_idx, wr_idx;
    logic        ra_short, rb_short, wr_short, wr_en;
    logic [7:0]  ra_data, rb_data, wr_data;
    logic [15:0] mem_addr;
    logic        mem_rd, mem_wr;
    logic [7:0]  mem_wdata, mem_rdata, io_rdata, sram_rdata;
    logic        io_sel, sram_sel;
    logic [5:0]  io_addr;
    logic [15:0] sram_addr, ptr_x, ptr_y, ptr_z;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #(CLK_P/2) clk = ~clk;

    regmap_file u_dut (
        .clk(clk), .rst_n(rst_n),
        .ra_idx(ra_idx), .ra_short(ra_short), .ra_data(ra_data),
        .rb_idx(rb_idx), .rb_short(rb_short), .rb_data(rb_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_short(wr_short), .wr_data(wr_data),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .io_rdata(io_rdata), .sram_rdata(sram_rdata),
        .io_sel(io_sel), .io_addr(io_addr),
        .sram_sel(sram_sel), .sram_addr(sram_addr),
        .ptr_x(ptr_x), .ptr_y(ptr_y), .ptr_z(ptr_z)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle();
        wr_en = 0; mem_rd = 0; mem_wr = 0;
        ra_short = 0; rb_short = 0; wr_short = 0;
    endtask

    task automatic read_a(input logic [4:0] idx, input logic sh);
        ra_idx = idx; ra_short = sh; #1;
    endtask

    // One instruction write; returns at the following falling edge.
    task automatic instr_write(input logic [4:0] idx, input logic sh, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1; wr_idx = idx; wr_short = sh; wr_data = d;
        @(negedge clk);
        idle();
    endtask

    task automatic mem_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        mem_wr = 1; mem_addr = a; mem_wdata = d;
        @(negedge clk);
        idle();
    endtask

    task automatic t_reset();
        for (int i = 0; i < 32; i++) begin
            read_a(5'(i), 0);
            chk("R1 reg zero", {8'h0, ra_data}, 16'h0);
        end
        chk("R1 ptr_x", ptr_x, 16'h0);
        chk("R1 ptr_y", ptr_y, 16'h0);
        chk("R1 ptr_z", ptr_z, 16'h0);
    endtask

    task automatic t_write_timing();
        @(negedge clk);
        wr_en = 1; wr_idx = 5; wr_short = 0; wr_data = 8'hA5;
        ra_idx = 5; ra_short = 0; #1;
        chk("R2 not same cycle", {8'h0, ra_data}, 16'h0);
        @(negedge clk);
        idle(); #1;
        chk("R2 port A next cycle", {8'h0, ra_data}, 16'h00A5);
        rb_idx = 5; rb_short = 0; #1;
        chk("R2 port B next cycle", {8'h0, rb_data}, 16'h00A5);
    endtask

    task automatic t_short();
        instr_write(5'b1_0011, 1, 8'h77);          // bit 4 set but ignored: r19
        read_a(19, 0);
        chk("R3 short write to r19", {8'h0, ra_data}, 16'h0077);
        read_a(3, 0);
        chk("R3 r3 untouched", {8'h0, ra_data}, 16'h0);
        read_a(3, 1);
        chk("R3 short read A", {8'h0, ra_data}, 16'h0077);
        rb_idx = 5'b0_0011; rb_short = 1; #1;
        chk("R3 short read B", {8'h0, rb_data}, 16'h0077);
        rb_short = 0;
    endtask

    task automatic t_mem_reg();
        mem_write(16'h0007, 8'h3C);
        read_a(7, 0);
        chk("R4 mem write r7", {8'h0, ra_data}, 16'h003C);
        mem_addr = 16'h0007; mem_rd = 1; #1;
        chk("R4 mem read r7", {8'h0, mem_rdata}, 16'h003C);
        chk("R10 reg region io_sel", {15'h0, io_sel}, 16'h0);
        chk("R10 reg region sram_sel", {15'h0, sram_sel}, 16'h0);
        mem_addr = 16'h001F; #1;
        chk("R10 0x1F no io_sel", {15'h0, io_sel}, 16'h0);
        mem_rd = 0;
    endtask

    task automatic t_io();
        @(negedge clk);
        mem_wr = 1; mem_addr = 16'h0025; mem_wdata = 8'hEE; #1;
        chk("R5 io_sel", {15'h0, io_sel}, 16'h1);
        chk("R5 io_addr", {10'h0, io_addr}, 16'h0005);
        chk("R10 io only", {15'h0, sram_sel}, 16'h0);
        @(negedge clk);
        idle();
        read_a(5, 0);
        chk("R5 r5 unchanged", {8'h0, ra_data}, 16'h00A5);
        mem_rd = 1; mem_addr = 16'h005F; io_rdata = 8'h5A; #1;
        chk("R5 top io_addr", {10'h0, io_addr}, 16'h003F);
        chk("R9 io read data", {8'h0, mem_rdata}, 16'h005A);
        mem_addr = 16'h0020; #1;
        chk("R5 0x20 io_sel", {15'h0, io_sel}, 16'h1);
        chk("R5 0x20 io_addr", {10'h0, io_addr}, 16'h0);
        mem_rd = 0; #1;
        chk("R10 idle io_sel", {15'h0, io_sel}, 16'h0);
    endtask

    task automatic t_sram();
        @(negedge clk);
        mem_wr = 1; mem_addr = 16'h0060; mem_wdata = 8'h99; #1;
        chk("R6 sram_sel", {15'h0, sram_sel}, 16'h1);
        chk("R6 base offset", sram_addr, 16'h0000);
        chk("R10 sram only", {15'h0, io_sel}, 16'h0);
        @(negedge clk);
        idle();
        read_a(0, 0);
        chk("R6 r0 unchanged", {8'h0, ra_data}, 16'h0);
        mem_rd = 1; mem_addr = 16'h1234; sram_rdata = 8'hC3; #1;
        chk("R6 offset", sram_addr, 16'h11D4);
        chk("R9 sram read data", {8'h0, mem_rdata}, 16'h00C3);
        mem_rd = 0; #1;
        chk("R10 idle sram_sel", {15'h0, sram_sel}, 16'h0);
    endtask

    task automatic t_ptrs();
        instr_write(26, 0, 8'h11);
        instr_write(27, 0, 8'h22);
        instr_write(12, 1, 8'h33);   // short 12 -> r28
        mem_write(16'h001D, 8'h44);  // r29
        instr_write(30, 0, 8'h55);
        instr_write(31, 0, 8'h66);
        #1;
        chk("R7 ptr_x", ptr_x, 16'h2211);
        chk("R7 ptr_y", ptr_y, 16'h4433);
        chk("R7 ptr_z", ptr_z, 16'h6655);
    endtask

    task automatic t_collide();
        @(negedge clk);
        wr_en = 1; wr_idx = 10; wr_data = 8'h11;
        mem_wr = 1; mem_addr = 16'h000A; mem_wdata = 8'h22;
        @(negedge clk);
        idle();
        read_a(10, 0);
        chk("R8 instr wins", {8'h0, ra_data}, 16'h0011);
        @(negedge clk);
        wr_en = 1; wr_idx = 11; wr_data = 8'hAB;
        mem_wr = 1; mem_addr = 16'h000C; mem_wdata = 8'hCD;
        @(negedge clk);
        idle();
        read_a(11, 0);
        chk("R8 both land instr", {8'h0, ra_data}, 16'h00AB);
        read_a(12, 0);
        chk("R8 both land mem", {8'h0, ra_data}, 16'h00CD);
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        #(CLK_P * 5000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected done");
            report();
        end
    end

    initial begin
        rst_n = 0; idle();
        ra_idx = 0; rb_idx = 0; wr_idx = 0; wr_data = 0;
        mem_addr = 0; mem_wdata = 0; io_rdata = 0; sram_rdata = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_write_timing();
        t_short();
        t_mem_reg();
        t_io();
        t_sram();
        t_ptrs();
        t_collide();
        done = 1;
        report();
    end
endmodule